// File: doc/BRIEF.md
# Split-Word Coherent Register Read Unit

This unit sits between a host port that reads 16 bits at a time and a bank of 32-bit registers whose contents may change on any cycle. A 32-bit value is fetched as two half-reads that target the same register, in either order. When the first half is requested, the unit captures the entire 32-bit word. It then serves the partner half from that captured copy, so the two halves always belong to the same instant, even if the live register moved in between.

Read side effects, such as clear-on-read, must not be lost and must not fire on a partial read. The unit therefore raises a one-cycle commit strobe, carrying the register address, only when a pair has been completed properly. A second half-read can break the pair in two ways: it names the same half again, or it names a different register. Neither is an error. The unit discards the open pair and treats the new read as the first half of a fresh pair. Registers flagged as 16-bit capable complete on a single half-read.

Top module: `dword_read_coherency`

## Requirements
- R1: Every request sampled on a rising clock edge produces `rdValid` high, with `rdData`, in the following cycle. A cycle with no request produces `rdValid` low in the following cycle.
- R2: A half-read that opens a pair returns the selected half of the live register value at the request edge (`rdHalf`=1 selects bits 31:16, 0 selects bits 15:0) and captures the whole 32-bit value.
- R3: The next request after an opening half-read that names the same register and the opposite half returns that half from the captured value, regardless of any change to the live register since the opening read. Idle cycles in between do not break the pair.
- R4: A pair may be opened with either the upper half or the lower half.
- R5: A request that repeats the half of the open pair on the same register discards the pair without a commit. It returns live data and opens a new pair with a fresh capture.
- R6: A request to a different register while a pair is open discards that pair without a commit and opens a new pair on the new register.
- R7: `commitStb` pulses for exactly the response cycle of a completing read, with `commitAddr` equal to that register's address. An opening or discarded half-read never produces a commit.
- R8: `pairValid` goes high with each response that completes a transfer and low with each response that does not. It holds its value in cycles without a response.
- R9: For a register whose `halfOnly` bit is set, each half-read returns live data, completes at once with a commit, and closes any open pair.
- R10: After reset, `rdValid`, `rdData`, `pairValid` and `commitStb` are low and no pair is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Half-read request, one per cycle |
| rdAddr | input | ADDR_W | Register index |
| rdHalf | input | 1 | 1 = bits 31:16, 0 = bits 15:0 |
| regFlat | input | NUM_REGS*2*HALF_W | Live register values, register i at bits i*32 upward |
| halfOnly | input | NUM_REGS | Per register: single half-read completes |
| rdData | output | HALF_W | Returned half |
| rdValid | output | 1 | Response valid |
| pairValid | output | 1 | Last response completed a transfer |
| commitStb | output | 1 | Read side-effect commit pulse |
| commitAddr | output | ADDR_W | Register whose side effects commit |

## Verification
The bench instantiates the unit with four registers and 16-bit halves, and flags register 3 as 16-bit capable. Because there are only four addresses, random traffic frequently repeats the same register. That makes same-half restarts, address switches, proper pairs in both orders, and single-half completions all common. The live registers are re-randomized before every request, so any second half that was not served from the captured copy shows up as a data mismatch.

// File: rtl/dwordrd_pkg.sv
package dwordrd_pkg;
  typedef struct packed {
    logic respond;
    logic loadSnap;
    logic useSnap;
    logic complete;
  } rdStrobe_t;
endpackage

// File: rtl/dwordrd_ctrl.sv
module dwordrd_ctrl
  import dwordrd_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int SLOTS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdHalf,
  input  logic [NUM_REGS-1:0] halfOnly,
  output rdStrobe_t         strb
);
  logic [SLOTS-1:0] flagPad;
  logic pendQ;
  logic [ADDR_W-1:0] pendAddrQ;
  logic pendHalfQ;
  logic isSingle;
  logic isSecond;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_flag
      if (i < NUM_REGS) begin : g_real
        assign flagPad[i] = halfOnly[i];
      end else begin : g_pad
        assign flagPad[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    isSingle = flagPad[rdAddr];
    isSecond = pendQ && (rdAddr == pendAddrQ) && (rdHalf != pendHalfQ) && !isSingle;
    strb.respond  = rdReq;
    strb.useSnap  = rdReq && isSecond;
    strb.complete = rdReq && (isSingle || isSecond);
    strb.loadSnap = rdReq && !isSingle && !isSecond;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ     <= 1'b0;
      pendAddrQ <= '0;
      pendHalfQ <= 1'b0;
    end else if (rdReq) begin
      pendQ     <= strb.loadSnap;
      pendAddrQ <= rdAddr;
      pendHalfQ <= rdHalf;
    end
  end

  // R6
  addr_switch_no_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && pendQ && (rdAddr != pendAddrQ) && !flagPad[rdAddr]) |-> !strb.complete);

  // R5
  same_half_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && pendQ && (rdAddr == pendAddrQ) && (rdHalf == pendHalfQ)) |-> strb.loadSnap);
endmodule

// File: rtl/dwordrd_datapath.sv
module dwordrd_datapath
  import dwordrd_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int SLOTS = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rdStrobe_t                  strb,
  input  logic [ADDR_W-1:0]          rdAddr,
  input  logic                       rdHalf,
  input  logic [NUM_REGS*WORD_W-1:0] regFlat,
  output logic [HALF_W-1:0]          rdData,
  output logic                       rdValid,
  output logic                       pairValid,
  output logic                       commitStb,
  output logic [ADDR_W-1:0]          commitAddr
);
  logic [WORD_W-1:0] wordArr [SLOTS];
  logic [WORD_W-1:0] liveWord;
  logic [WORD_W-1:0] snapQ;
  logic [HALF_W-1:0] liveHalf;
  logic [HALF_W-1:0] snapHalf;
  logic [HALF_W-1:0] nextData;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_word
      if (i < NUM_REGS) begin : g_real
        assign wordArr[i] = regFlat[i*WORD_W +: WORD_W];
      end else begin : g_pad
        assign wordArr[i] = '0;
      end
    end
  endgenerate

  always_comb begin
    liveWord = wordArr[rdAddr];
    liveHalf = rdHalf ? liveWord[WORD_W-1:HALF_W] : liveWord[HALF_W-1:0];
    snapHalf = rdHalf ? snapQ[WORD_W-1:HALF_W] : snapQ[HALF_W-1:0];
    nextData = strb.useSnap ? snapHalf : liveHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ      <= '0;
      rdData     <= '0;
      rdValid    <= 1'b0;
      pairValid  <= 1'b0;
      commitStb  <= 1'b0;
      commitAddr <= '0;
    end else begin
      if (strb.loadSnap) snapQ <= liveWord;
      rdValid   <= strb.respond;
      rdData    <= strb.respond ? nextData : '0;
      commitStb <= strb.complete;
      if (strb.respond) pairValid <= strb.complete;
      if (strb.complete) commitAddr <= rdAddr;
    end
  end

  // R7
  commit_with_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (rdValid && pairValid));

  // R3
  snap_only_on_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.useSnap |-> (strb.complete && !strb.loadSnap));
endmodule

// File: rtl/dword_read_coherency.sv
module dword_read_coherency
  import dwordrd_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdReq,
  input  logic [ADDR_W-1:0]          rdAddr,
  input  logic                       rdHalf,
  input  logic [NUM_REGS*WORD_W-1:0] regFlat,
  input  logic [NUM_REGS-1:0]        halfOnly,
  output logic [HALF_W-1:0]          rdData,
  output logic                       rdValid,
  output logic                       pairValid,
  output logic                       commitStb,
  output logic [ADDR_W-1:0]          commitAddr
);
  rdStrobe_t strb;

  dwordrd_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdHalf(rdHalf), .halfOnly(halfOnly), .strb(strb)
  );

  dwordrd_datapath #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .rdHalf(rdHalf),
    .regFlat(regFlat), .rdData(rdData), .rdValid(rdValid),
    .pairValid(pairValid), .commitStb(commitStb), .commitAddr(commitAddr)
  );

  // R1
  response_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  // R1
  no_response_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  // R8
  pair_status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(pairValid));
endmodule

// File: tb/sim_dword_read_coherency.sv
module sim_dword_read_coherency;
  localparam int NR = 4;
  localparam int HW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdReq = 1'b0;
  logic [1:0] rdAddr = '0;
  logic rdHalf = 1'b0;
  logic [31:0] regsTb [NR];
  logic [NR*32-1:0] regFlat;
  logic [NR-1:0] halfOnly = 4'b1000;
  logic [HW-1:0] rdData;
  logic rdValid, pairValid, commitStb;
  logic [1:0] commitAddr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic expValid = 0, expPair = 0, expCommit = 0;
  logic [15:0] expData = '0;
  logic [1:0] expCommitAddr = '0;
  string expTag = "R10";
  logic pendM = 0, pendHalfM = 0;
  logic [1:0] pendAddrM = '0;
  logic [31:0] snapM = '0;

  always #5 clk = ~clk;

  assign regFlat = {regsTb[3], regsTb[2], regsTb[1], regsTb[0]};

  dword_read_coherency #(.NUM_REGS(NR), .HALF_W(HW)) u0 (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr), .rdHalf(rdHalf),
    .regFlat(regFlat), .halfOnly(halfOnly), .rdData(rdData), .rdValid(rdValid),
    .pairValid(pairValid), .commitStb(commitStb), .commitAddr(commitAddr)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pick(input logic [31:0] w, input logic h);
    return h ? w[31:16] : w[15:0];
  endfunction

  task automatic step(input logic req, input logic [1:0] a, input logic h);
    logic single, second;
    @(negedge clk);
    chk("R1", "rdValid", {31'b0, rdValid}, {31'b0, expValid});
    if (expValid) chk(expTag, "rdData", {16'b0, rdData}, {16'b0, expData});
    chk(expCommit ? "R7" : "R7", "commitStb", {31'b0, commitStb}, {31'b0, expCommit});
    if (expCommit) chk(expTag, "commitAddr", {30'b0, commitAddr}, {30'b0, expCommitAddr});
    chk("R8", "pairValid", {31'b0, pairValid}, {31'b0, expPair});
    for (int i = 0; i < NR; i++) regsTb[i] = $urandom;
    rdReq = req; rdAddr = a; rdHalf = h;
    expValid = req;
    expCommit = 1'b0;
    if (req) begin
      single = halfOnly[a];
      second = pendM && (a == pendAddrM) && (h != pendHalfM) && !single;
      if (second) begin
        expData = pick(snapM, h); expTag = "R3";
      end else begin
        expData = pick(regsTb[a], h);
        if (single) expTag = "R9";
        else if (!pendM) expTag = (h ? "R4" : "R2");
        else if (a != pendAddrM) expTag = "R6";
        else expTag = "R5";
        if (!single) snapM = regsTb[a];
      end
      pendM = !single && !second;
      pendAddrM = a; pendHalfM = h;
      expCommit = single || second;
      expCommitAddr = a;
      expPair = expCommit;
    end
  endtask

  initial begin
    int unsigned wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) regsTb[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "rdValid", {31'b0, rdValid}, 32'd0);
    chk("R10", "rdData", {16'b0, rdData}, 32'd0);
    chk("R10", "pairValid", {31'b0, pairValid}, 32'd0);
    chk("R10", "commitStb", {31'b0, commitStb}, 32'd0);
    rstN = 1'b1;
    // R2/R3: lower then idle then upper
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0); step(1, 0, 1);
    // R4: upper first
    step(1, 1, 1); step(1, 1, 0);
    // R5: same half twice then partner
    step(1, 2, 0); step(1, 2, 0); step(1, 2, 1);
    // R6: address switch
    step(1, 0, 1); step(1, 1, 0); step(1, 0, 0); step(1, 1, 1);
    // R9: half-only register, also breaking an open pair
    step(1, 3, 0); step(1, 0, 0); step(1, 3, 1); step(1, 0, 1); step(1, 0, 0);
    // abandoned pair then idle: no commit
    step(1, 2, 1); step(0, 0, 0); step(0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, 2'($urandom % 4), 1'($urandom % 2));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule